// File: doc/BRIEF.md
# Multi-format video pixel input capture

This block is the capture stage at the front of a video encoder. It runs on a single clock at twice the pixel rate and latches the incoming pixel bus. The bus can be a byte-wide 4:2:2 luma/chroma stream, a byte-wide stream with embedded timing codes, 16-bit luma/chroma, 16-bit RGB or 24-bit RGB. The edges on which data is taken depend on the format and on the 2X upscale setting. Those edges are qualified by the phase of a half-rate clock. The block can generate that half-rate clock itself, or take it from a pin.

In the byte-wide formats the block splits the stream into a pixel pair: blue chroma, first luma, red chroma, second luma. The overlay/mode bits are captured only on the luma bytes. The byte order restarts at blue chroma whenever blanking ends. Wide formats produce one word per capture. Horizontal sync, vertical sync and blank each have their own direction. When they are inputs they are sampled on capture edges. When they are outputs they are re-timed to the output edge of the active mode. The field flag is always driven out.

Top module: `vid_capture`

## Requirements
- R1: With `fmt_sel`=0 (byte 4:2:2) and `upscale_en`=0, one byte is taken from `pix_in[7:0]` on every rising clock edge. Four consecutive active bytes are read as blue chroma, luma 0, red chroma and luma 1. The pair appears on `out_cb/out_y0/out_cr/out_y1` on the edge that takes luma 1.
- R2: While the effective blank is high (1 = blanking), the byte position is held at blue chroma. A partly received pair is dropped, and the first active byte after blanking is always blue chroma.
- R3: `out_ovl0` holds `ovl_in` as sampled with luma 0, and `out_ovl1` holds it as sampled with luma 1. Values present during chroma bytes never appear on these outputs.
- R4: With `fmt_sel`=0 and `upscale_en`=1, data and sync/blank inputs are taken only on edges where the half-rate phase is 0.
- R5: For `fmt_sel`=1 (16-bit luma/chroma), 2 (16-bit RGB) and 3 (24-bit RGB) without upscale, one word is taken on each edge where the phase is 0. It is put on `out_wide`; for codes 1 and 2, bits 23:16 read 0. `out_wide_ovl` carries `ovl_in` from the same edge.
- R6: For wide formats with upscale, a word is taken only on every second phase-0 edge. After reset the first phase-0 edge is skipped, giving one capture per four clocks.
- R7: With `fmt_sel`=4 (byte stream with timing codes), bytes are taken on every edge whatever `upscale_en` is, and both overlay outputs read 0.
- R8: With `clk_out_en`=1, `clk_half_o` is 0 in reset and inverts on every edge, and it serves as the phase. With `clk_out_en`=0 the phase is `half_clk_in`, and that pin has no effect in mode 0 without upscale.
- R9: The sync/blank output enables follow `sync_dir_out` and `blank_dir_out`. In phase-qualified modes (mode 0 with upscale, or any wide mode), `hsync_o/vsync_o/blank_o/field_o` change only on phase-1 edges. In other modes they change on every edge. `field_o` is always driven.
- R10: `out_valid` is a single-cycle strobe, high in the cycle after each completed pair or wide word, and never high two cycles running.
- R11: Synchronous active-high reset clears the half-rate divider, the byte position, the upscale edge counter and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Twice-pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 3 | Input format code (0..4) |
| upscale_en | input | 1 | 2X upscale setting |
| clk_out_en | input | 1 | 1: half-rate clock generated here; 0: taken from pin |
| half_clk_in | input | 1 | External half-rate clock |
| clk_half_o | output | 1 | Generated half-rate clock |
| clk_half_oe | output | 1 | Drive enable for the half-rate clock pin |
| pix_in | input | 24 | Pixel bus |
| ovl_in | input | 5 | Overlay and mode bits |
| blank_in | input | 1 | Blank from pin (1 = blanking) |
| hsync_in | input | 1 | Horizontal sync from pin |
| vsync_in | input | 1 | Vertical sync from pin |
| sync_dir_out | input | 1 | 1: sync pins are outputs |
| blank_dir_out | input | 1 | 1: blank pin is an output |
| tim_hs | input | 1 | Internal horizontal sync |
| tim_vs | input | 1 | Internal vertical sync |
| tim_blank | input | 1 | Internal blank |
| tim_field | input | 1 | Internal field flag |
| hsync_o | output | 1 | Re-timed horizontal sync out |
| vsync_o | output | 1 | Re-timed vertical sync out |
| blank_o | output | 1 | Re-timed blank out |
| field_o | output | 1 | Re-timed field flag |
| hsync_oe | output | 1 | Horizontal sync drive enable |
| vsync_oe | output | 1 | Vertical sync drive enable |
| blank_oe | output | 1 | Blank drive enable |
| cap_hs | output | 1 | Captured horizontal sync input |
| cap_vs | output | 1 | Captured vertical sync input |
| out_valid | output | 1 | Result strobe |
| out_cb | output | 8 | Blue chroma of the pair |
| out_y0 | output | 8 | First luma of the pair |
| out_cr | output | 8 | Red chroma of the pair |
| out_y1 | output | 8 | Second luma of the pair |
| out_ovl0 | output | 5 | Overlay taken with first luma |
| out_ovl1 | output | 5 | Overlay taken with second luma |
| out_wide | output | 24 | Captured wide word |
| out_wide_ovl | output | 5 | Overlay taken with the wide word |

## Verification
On every cycle the assertions check four things: the valid strobe is one cycle wide, the generated half-rate clock inverts each edge, the overlay outputs stay zero in the timing-code byte mode, and the sync/blank/field outputs move only on phase-1 edges in phase-qualified modes. Some behaviour can only be shown by the bench scenarios driving aligned byte and word streams against a queued model. Those scenarios cover the byte ordering and its restart after blanking, overlay selection on luma bytes, the capture rates per format, the masking of narrow wide words, and the effect of an external half-rate clock.

// File: rtl/vid_cap_pkg.sv
package vid_cap_pkg;

    localparam int BYTE_W = 8;
    localparam int WIDE_W = 24;
    localparam int OVL_W  = 5;

    typedef enum logic [2:0] {
        FMT_BYTE422 = 3'd0,
        FMT_YC16    = 3'd1,
        FMT_RGB16   = 3'd2,
        FMT_RGB24   = 3'd3,
        FMT_BYTECOD = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        POS_CB = 2'd0,
        POS_Y0 = 2'd1,
        POS_CR = 2'd2,
        POS_Y1 = 2'd3
    } bpos_e;

    function automatic logic is_byte_fmt(input fmt_e f);
        return (f == FMT_BYTE422) || (f == FMT_BYTECOD);
    endfunction

    function automatic logic is_phase_qual(input fmt_e f, input logic up);
        return (f == FMT_BYTE422 && up) || !is_byte_fmt(f);
    endfunction

endpackage

// File: rtl/vid_cap_phase.sv
module vid_cap_phase
    import vid_cap_pkg::*;
(
    input  logic clk2,
    input  logic rst,
    input  fmt_e fmt,
    input  logic upscale_en,
    input  logic clk_out_en,
    input  logic half_clk_in,
    output logic clk_half_o,
    output logic phase,
    output logic cap_en,
    output logic out_en
);
    logic ph_q;
    logic skip_q;
    logic wide_up;

    assign phase      = clk_out_en ? ph_q : half_clk_in;
    assign clk_half_o = ph_q;
    assign wide_up    = !is_byte_fmt(fmt) && upscale_en;

    always_ff @(posedge clk2) begin
        if (rst) begin
            ph_q   <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (wide_up && !phase)
                skip_q <= ~skip_q;
        end
    end

    always_comb begin
        unique case (fmt)
            FMT_BYTE422: cap_en = upscale_en ? !phase : 1'b1;
            FMT_BYTECOD: cap_en = 1'b1;
            default:     cap_en = upscale_en ? (!phase && skip_q) : !phase;
        endcase
        out_en = is_phase_qual(fmt, upscale_en) ? phase : 1'b1;
    end

endmodule

// File: rtl/vid_cap_demux.sv
module vid_cap_demux
    import vid_cap_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int WW = WIDE_W,
    parameter int OW = OVL_W
) (
    input  logic          clk2,
    input  logic          rst,
    input  logic          cap_en,
    input  logic          byte_mode,
    input  logic          ovl_block,
    input  logic          active,
    input  logic [WW-1:0] word_in,
    input  logic [OW-1:0] ovl_in,
    output logic          out_valid,
    output logic [BW-1:0] out_cb,
    output logic [BW-1:0] out_y0,
    output logic [BW-1:0] out_cr,
    output logic [BW-1:0] out_y1,
    output logic [OW-1:0] out_ovl0,
    output logic [OW-1:0] out_ovl1,
    output logic [WW-1:0] out_wide,
    output logic [OW-1:0] out_wide_ovl
);
    bpos_e         pos_q;
    logic [BW-1:0] cb_q, y0_q, cr_q;
    logic [OW-1:0] ov0_q;
    logic [BW-1:0] byte_in;
    logic [OW-1:0] ovl_eff;

    assign byte_in = word_in[BW-1:0];
    assign ovl_eff = ovl_block ? '0 : ovl_in;

    always_ff @(posedge clk2) begin
        if (rst) begin
            pos_q        <= POS_CB;
            cb_q         <= '0;
            y0_q         <= '0;
            cr_q         <= '0;
            ov0_q        <= '0;
            out_valid    <= 1'b0;
            out_cb       <= '0;
            out_y0       <= '0;
            out_cr       <= '0;
            out_y1       <= '0;
            out_ovl0     <= '0;
            out_ovl1     <= '0;
            out_wide     <= '0;
            out_wide_ovl <= '0;
        end else begin
            out_valid <= 1'b0;
            if (cap_en) begin
                if (byte_mode) begin
                    if (!active) begin
                        pos_q <= POS_CB;
                    end else begin
                        unique case (pos_q)
                            POS_CB: begin
                                cb_q  <= byte_in;
                                pos_q <= POS_Y0;
                            end
                            POS_Y0: begin
                                y0_q  <= byte_in;
                                ov0_q <= ovl_eff;
                                pos_q <= POS_CR;
                            end
                            POS_CR: begin
                                cr_q  <= byte_in;
                                pos_q <= POS_Y1;
                            end
                            POS_Y1: begin
                                out_cb    <= cb_q;
                                out_y0    <= y0_q;
                                out_cr    <= cr_q;
                                out_y1    <= byte_in;
                                out_ovl0  <= ov0_q;
                                out_ovl1  <= ovl_eff;
                                out_valid <= 1'b1;
                                pos_q     <= POS_CB;
                            end
                        endcase
                    end
                end else if (active) begin
                    out_wide     <= word_in;
                    out_wide_ovl <= ovl_eff;
                    out_valid    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vid_cap_sync.sv
module vid_cap_sync (
    input  logic clk2,
    input  logic rst,
    input  logic cap_en,
    input  logic out_en,
    input  logic sync_dir_out,
    input  logic blank_dir_out,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic blank_in,
    input  logic tim_hs,
    input  logic tim_vs,
    input  logic tim_blank,
    input  logic tim_field,
    output logic blank_eff,
    output logic hsync_o,
    output logic vsync_o,
    output logic blank_o,
    output logic field_o,
    output logic hsync_oe,
    output logic vsync_oe,
    output logic blank_oe,
    output logic cap_hs,
    output logic cap_vs
);
    assign blank_eff = blank_dir_out ? tim_blank : blank_in;
    assign hsync_oe  = sync_dir_out;
    assign vsync_oe  = sync_dir_out;
    assign blank_oe  = blank_dir_out;

    always_ff @(posedge clk2) begin
        if (rst) begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            blank_o <= 1'b1;
            field_o <= 1'b0;
            cap_hs  <= 1'b0;
            cap_vs  <= 1'b0;
        end else begin
            if (out_en) begin
                hsync_o <= tim_hs;
                vsync_o <= tim_vs;
                blank_o <= tim_blank;
                field_o <= tim_field;
            end
            if (cap_en && !sync_dir_out) begin
                cap_hs <= hsync_in;
                cap_vs <= vsync_in;
            end
        end
    end

endmodule

// File: rtl/vid_capture.sv
module vid_capture
    import vid_cap_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int WW = WIDE_W,
    parameter int OW = OVL_W
) (
    input  logic          clk2,
    input  logic          rst,
    input  logic [2:0]    fmt_sel,
    input  logic          upscale_en,
    input  logic          clk_out_en,
    input  logic          half_clk_in,
    output logic          clk_half_o,
    output logic          clk_half_oe,
    input  logic [WW-1:0] pix_in,
    input  logic [OW-1:0] ovl_in,
    input  logic          blank_in,
    input  logic          hsync_in,
    input  logic          vsync_in,
    input  logic          sync_dir_out,
    input  logic          blank_dir_out,
    input  logic          tim_hs,
    input  logic          tim_vs,
    input  logic          tim_blank,
    input  logic          tim_field,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          blank_o,
    output logic          field_o,
    output logic          hsync_oe,
    output logic          vsync_oe,
    output logic          blank_oe,
    output logic          cap_hs,
    output logic          cap_vs,
    output logic          out_valid,
    output logic [BW-1:0] out_cb,
    output logic [BW-1:0] out_y0,
    output logic [BW-1:0] out_cr,
    output logic [BW-1:0] out_y1,
    output logic [OW-1:0] out_ovl0,
    output logic [OW-1:0] out_ovl1,
    output logic [WW-1:0] out_wide,
    output logic [OW-1:0] out_wide_ovl
);
    localparam int NARROW_W = 2 * BW;

    fmt_e          fmt;
    logic          cap_phase;
    logic          cap_en;
    logic          out_en;
    logic          blank_eff;
    logic [WW-1:0] word_in;

    assign fmt         = fmt_e'(fmt_sel);
    assign clk_half_oe = clk_out_en;

    generate
        if (WW > NARROW_W) begin : g_mask
            assign word_in = (fmt == FMT_RGB24) ? pix_in
                           : {{(WW - NARROW_W){1'b0}}, pix_in[NARROW_W-1:0]};
        end else begin : g_nomask
            assign word_in = pix_in;
        end
    endgenerate

    vid_cap_phase u_phase (
        .clk2        (clk2),
        .rst         (rst),
        .fmt         (fmt),
        .upscale_en  (upscale_en),
        .clk_out_en  (clk_out_en),
        .half_clk_in (half_clk_in),
        .clk_half_o  (clk_half_o),
        .phase       (cap_phase),
        .cap_en      (cap_en),
        .out_en      (out_en)
    );

    vid_cap_sync u_sync (
        .clk2          (clk2),
        .rst           (rst),
        .cap_en        (cap_en),
        .out_en        (out_en),
        .sync_dir_out  (sync_dir_out),
        .blank_dir_out (blank_dir_out),
        .hsync_in      (hsync_in),
        .vsync_in      (vsync_in),
        .blank_in      (blank_in),
        .tim_hs        (tim_hs),
        .tim_vs        (tim_vs),
        .tim_blank     (tim_blank),
        .tim_field     (tim_field),
        .blank_eff     (blank_eff),
        .hsync_o       (hsync_o),
        .vsync_o       (vsync_o),
        .blank_o       (blank_o),
        .field_o       (field_o),
        .hsync_oe      (hsync_oe),
        .vsync_oe      (vsync_oe),
        .blank_oe      (blank_oe),
        .cap_hs        (cap_hs),
        .cap_vs        (cap_vs)
    );

    vid_cap_demux #(.BW(BW), .WW(WW), .OW(OW)) u_demux (
        .clk2         (clk2),
        .rst          (rst),
        .cap_en       (cap_en),
        .byte_mode    (is_byte_fmt(fmt)),
        .ovl_block    (fmt == FMT_BYTECOD),
        .active       (!blank_eff),
        .word_in      (word_in),
        .ovl_in       (ovl_in),
        .out_valid    (out_valid),
        .out_cb       (out_cb),
        .out_y0       (out_y0),
        .out_cr       (out_cr),
        .out_y1       (out_y1),
        .out_ovl0     (out_ovl0),
        .out_ovl1     (out_ovl1),
        .out_wide     (out_wide),
        .out_wide_ovl (out_wide_ovl)
    );

endmodule

// File: rtl/vid_capture_chk.sv
module vid_capture_chk #(
    parameter int OW = 5
) (
    input logic          clk2,
    input logic          rst,
    input logic [2:0]    fmt_sel,
    input logic          upscale_en,
    input logic          clk_out_en,
    input logic          phase,
    input logic          clk_half_o,
    input logic          out_valid,
    input logic [OW-1:0] out_ovl0,
    input logic [OW-1:0] out_ovl1,
    input logic          hsync_o,
    input logic          blank_o,
    input logic          field_o
);
    logic qual;
    assign qual = (fmt_sel == 3'd0 && upscale_en) || (fmt_sel != 3'd0 && fmt_sel != 3'd4);

    // R10: strobe lasts one cycle
    p_strobe_single_r10: assert property (@(posedge clk2) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: generated half-rate clock inverts every edge
    p_half_toggle_r8: assert property (@(posedge clk2) disable iff (rst)
        clk_out_en |=> (clk_half_o != $past(clk_half_o)));

    // R7: overlay outputs stay zero in the timing-code byte mode
    p_bytecod_ovl_zero_r7: assert property (@(posedge clk2) disable iff (rst)
        (fmt_sel == 3'd4 && out_valid) |-> (out_ovl0 == '0 && out_ovl1 == '0));

    // R9: in phase-qualified modes the timing outputs move only on phase-1 edges
    p_sync_phase_r9: assert property (@(posedge clk2) disable iff (rst)
        (qual && $past(qual) && !($stable(hsync_o) && $stable(blank_o) && $stable(field_o)))
        |-> $past(phase));

    // R11: reset leaves no strobe and a low divider
    p_reset_state_r11: assert property (@(posedge clk2)
        $past(rst) |-> (!out_valid && !clk_half_o));

endmodule

bind vid_capture vid_capture_chk #(.OW(OW)) u_chk (
    .clk2       (clk2),
    .rst        (rst),
    .fmt_sel    (fmt_sel),
    .upscale_en (upscale_en),
    .clk_out_en (clk_out_en),
    .phase      (cap_phase),
    .clk_half_o (clk_half_o),
    .out_valid  (out_valid),
    .out_ovl0   (out_ovl0),
    .out_ovl1   (out_ovl1),
    .hsync_o    (hsync_o),
    .blank_o    (blank_o),
    .field_o    (field_o)
);

// File: tb/vid_capture_bench.sv
module vid_capture_bench;
    logic        clk2 = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt_sel = 3'd0;
    logic        upscale_en = 1'b0, clk_out_en = 1'b1, half_clk_in = 1'b0;
    logic        clk_half_o, clk_half_oe;
    logic [23:0] pix_in = '0;
    logic [4:0]  ovl_in = '0;
    logic        blank_in = 1'b1, hsync_in = 1'b0, vsync_in = 1'b0;
    logic        sync_dir_out = 1'b0, blank_dir_out = 1'b0;
    logic        tim_hs = 1'b0, tim_vs = 1'b0, tim_blank = 1'b1, tim_field = 1'b0;
    logic        hsync_o, vsync_o, blank_o, field_o, hsync_oe, vsync_oe, blank_oe;
    logic        cap_hs, cap_vs, out_valid;
    logic [7:0]  out_cb, out_y0, out_cr, out_y1;
    logic [4:0]  out_ovl0, out_ovl1, out_wide_ovl;
    logic [23:0] out_wide;

    int          vectors = 0;
    int          miscompares = 0;
    logic [63:0] exp_q[$];
    string       cur_req = "R1";
    logic        wide_mode = 1'b0;

    always #5 clk2 = ~clk2;

    vid_capture u_vid_capture (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each strobe
    always @(negedge clk2) begin
        if (!rst && out_valid) begin
            logic [63:0] obs;
            obs = wide_mode ? {35'b0, out_wide, out_wide_ovl}
                            : {22'b0, out_cb, out_y0, out_cr, out_y1, out_ovl0, out_ovl1};
            if (exp_q.size() == 0) begin
                chk({cur_req, " unexpected strobe"}, obs, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(cur_req, obs, e);
            end
        end
    end

    task automatic reset_dut();
        rst = 1'b1;
        blank_in = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge clk2);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        blank_in = 1'b1;
        repeat (n) begin
            pix_in = 24'hEEEEEE;
            @(negedge clk2);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic [4:0] o, input int hold);
        blank_in = 1'b0;
        pix_in = {16'hA5A5, b};
        ovl_in = o;
        repeat (hold) @(negedge clk2);
    endtask

    task automatic send_pair(input logic [7:0] cb, y0, cr, y1,
                             input logic [4:0] o0, o1, input int hold, input logic ovl_zero);
        exp_q.push_back({22'b0, cb, y0, cr, y1, ovl_zero ? 5'd0 : o0, ovl_zero ? 5'd0 : o1});
        put_byte(cb, ~o0, hold);
        put_byte(y0, o0, hold);
        put_byte(cr, ~o1, hold);
        put_byte(y1, o1, hold);
    endtask

    task automatic send_wide(input logic [23:0] w, input logic [4:0] o, input int hold,
                             input logic narrow);
        exp_q.push_back({35'b0, narrow ? {8'h00, w[15:0]} : w, o});
        blank_in = 1'b0;
        pix_in = w;
        ovl_in = o;
        repeat (hold) @(negedge clk2);
    endtask

    task automatic drain(input string req);
        idle(8);
        chk({req, " scoreboard empty"}, 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk2);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk2);
        chk("R11 valid in reset", 64'(out_valid), 64'h0);
        chk("R11 divider in reset", 64'(clk_half_o), 64'h0);

        // R1 R3: byte 4:2:2, no upscale
        cur_req = "R1";
        fmt_sel = 3'd0; upscale_en = 1'b0; wide_mode = 1'b0;
        reset_dut();
        idle(2);
        send_pair(8'h10, 8'h21, 8'h32, 8'h43, 5'h01, 5'h1E, 1, 1'b0);
        send_pair(8'h80, 8'hF0, 8'h7F, 8'h05, 5'h0A, 5'h15, 1, 1'b0);
        cur_req = "R3";
        send_pair(8'h00, 8'hFF, 8'hFF, 8'h00, 5'h1F, 5'h00, 1, 1'b0);
        drain("R1");

        // R2: partial pair dropped at blank, restart at blue chroma
        cur_req = "R2";
        put_byte(8'h99, 5'h3, 1);
        put_byte(8'h98, 5'h4, 1);
        idle(1);
        send_pair(8'h11, 8'h22, 8'h33, 8'h44, 5'h06, 5'h09, 1, 1'b0);
        drain("R2");

        // R8: pin half clock ignored in mode 0 without upscale
        cur_req = "R8";
        clk_out_en = 1'b0; half_clk_in = 1'b1;
        reset_dut();
        idle(2);
        send_pair(8'h5A, 8'h6B, 8'h7C, 8'h8D, 5'h02, 5'h04, 1, 1'b0);
        drain("R8");

        // R4: byte 4:2:2 with upscale, generated phase
        cur_req = "R4";
        clk_out_en = 1'b1; upscale_en = 1'b1;
        reset_dut();
        @(negedge clk2);
        chk("R8 divider after first edge", 64'(clk_half_o), 64'h1);
        @(negedge clk2);
        chk("R8 divider after second edge", 64'(clk_half_o), 64'h0);
        idle(2);
        send_pair(8'h12, 8'h34, 8'h56, 8'h78, 5'h11, 5'h0C, 2, 1'b0);
        send_pair(8'h9A, 8'hBC, 8'hDE, 8'hF0, 5'h07, 5'h18, 2, 1'b0);
        drain("R4");

        // R8 R4: external phase held high blocks capture
        cur_req = "R8";
        clk_out_en = 1'b0; half_clk_in = 1'b1;
        reset_dut();
        idle(2);
        put_byte(8'h01, 5'h0, 2); put_byte(8'h02, 5'h0, 2);
        put_byte(8'h03, 5'h0, 2); put_byte(8'h04, 5'h0, 2);
        drain("R8 phase-high blocks capture");
        half_clk_in = 1'b0;
        reset_dut();
        idle(2);
        send_pair(8'hC1, 8'hC2, 8'hC3, 8'hC4, 5'h13, 5'h0D, 1, 1'b0);
        drain("R8 phase-low every edge");
        clk_out_en = 1'b1;

        // R5: wide formats without upscale
        cur_req = "R5";
        upscale_en = 1'b0; wide_mode = 1'b1;
        fmt_sel = 3'd3;
        reset_dut();
        idle(2);
        send_wide(24'hABCDEF, 5'h15, 2, 1'b0);
        send_wide(24'h123456, 5'h0A, 2, 1'b0);
        drain("R5 rgb24");
        fmt_sel = 3'd1;
        reset_dut();
        idle(2);
        send_wide(24'hFF8040, 5'h03, 2, 1'b1);
        drain("R5 yc16 mask");
        fmt_sel = 3'd2;
        reset_dut();
        idle(2);
        send_wide(24'h77F00F, 5'h1C, 2, 1'b1);
        drain("R5 rgb16 mask");

        // R6: wide formats with upscale, one word per four clocks
        cur_req = "R6";
        upscale_en = 1'b1; fmt_sel = 3'd2;
        reset_dut();
        idle(4);
        send_wide(24'h00BEEF, 5'h08, 4, 1'b1);
        send_wide(24'h00CAFE, 5'h10, 4, 1'b1);
        send_wide(24'h001234, 5'h01, 4, 1'b1);
        drain("R6");

        // R7: timing-code byte stream, upscale ignored, overlay forced to zero
        cur_req = "R7";
        fmt_sel = 3'd4; upscale_en = 1'b1; wide_mode = 1'b0;
        reset_dut();
        idle(2);
        send_pair(8'hFF, 8'h00, 8'h00, 8'hAB, 5'h1F, 5'h1F, 1, 1'b1);
        send_pair(8'h80, 8'h10, 8'h80, 8'h10, 5'h05, 5'h0A, 1, 1'b1);
        drain("R7");

        // R9: timing outputs in a phase-qualified mode
        cur_req = "R9";
        fmt_sel = 3'd3; upscale_en = 1'b0; sync_dir_out = 1'b1; blank_dir_out = 1'b1;
        reset_dut();
        tim_hs = 1'b1; tim_field = 1'b1; tim_blank = 1'b1;
        @(negedge clk2);
        chk("R9 hold on phase-0 edge", {62'b0, hsync_o, field_o}, 64'h0);
        chk("R9 output enables", {61'b0, hsync_oe, vsync_oe, blank_oe}, 64'h7);
        @(negedge clk2);
        chk("R9 update on phase-1 edge", {62'b0, hsync_o, field_o}, 64'h3);

        // R9: non-qualified mode follows every edge
        fmt_sel = 3'd0;
        reset_dut();
        tim_vs = 1'b1;
        @(negedge clk2);
        chk("R9 every edge in mode 0", 64'(vsync_o), 64'h1);

        // R4 R9: sync inputs captured when pins are inputs
        sync_dir_out = 1'b0; blank_dir_out = 1'b0; tim_vs = 1'b0;
        fmt_sel = 3'd0; upscale_en = 1'b1;
        reset_dut();
        hsync_in = 1'b1;
        @(negedge clk2);
        chk("R4 sync input on phase-0 edge", 64'(cap_hs), 64'h1);
        hsync_in = 1'b0;
        @(negedge clk2);
        chk("R4 sync input held on phase-1 edge", 64'(cap_hs), 64'h1);
        @(negedge clk2);
        chk("R4 sync input next phase-0 edge", 64'(cap_hs), 64'h0);
        chk("R9 enables off", {61'b0, hsync_oe, vsync_oe, blank_oe}, 64'h0);

        // R10: total strobes matched the model (no leftovers)
        chk("R10 final scoreboard", 64'(exp_q.size()), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule